// File: doc/BRIEF.md
# Depth-Cascadable Synchronous FIFO Slice

A FIFO slice with independent write and read clocks, a parameterised depth of 2^AW words and an 18-bit data path by default. Write and read pointers cross between the clock domains in Gray code through two-flop synchronisers. From these the slice derives five active-low status flags: empty, full, half-full, almost-empty and almost-full.

Slices can be joined into a ring to form a deeper buffer. A write token and a read token travel around the ring. A slice accepts writes only while it holds the write token, and reads only while it holds the read token. When a slice writes its last physical location, it releases the write token and drives a one-cycle pass pulse to the next slice. Reads hand the read token on in the same way. The slice whose `chain_head_n` is low owns both tokens after reset.

With `CASCADE` set to 0 the slice is a plain standalone FIFO. It owns both tokens permanently and never passes them on.

Top module: `sync_fifo_slice`

## Requirements
- R1: While `rst_n` is low, and straight after it, the outputs read as follows: `empty_n`=0, `full_n`=1, `half_n`=1, `aempty_n`=0, `afull_n`=1, both pass outputs 0 and `dout`=0. At that point only a slice with `chain_head_n`=0 holds the tokens.
- R2: Each accepted read loads the oldest unread word of the slice into `dout` on that `rclk` edge. Otherwise `dout` holds its value.
- R3: A write is accepted on a `wclk` edge only when three conditions hold: `wr_en`=1, the write token is held, and `full_n`=1. `full_n` is low while DEPTH words are unread, as seen through the synchronised read pointer. `full_n` rises on the second `wclk` edge after the read that frees a word.
- R4: A read is accepted on an `rclk` edge only when three conditions hold: `rd_en`=1, the read token is held, and `empty_n`=1. `empty_n` rises on the second `rclk` edge after the `wclk` edge of the first write.
- R5: With CASCADE=1, `wpass_out` is high for exactly the one `wclk` cycle after the edge that writes physical location DEPTH-1. The write token is released on that edge. It is regained on a `wclk` edge that samples `wpass_in` high.
- R6: With CASCADE=1, `rpass_out` is high for exactly the one `rclk` cycle after the edge that reads physical location DEPTH-1. The read token is released on that edge. It is regained on an `rclk` edge that samples `rpass_in` high.
- R7: With CASCADE=0, both tokens are held permanently. `wpass_in` and `rpass_in` have no effect, and both pass outputs stay 0.
- R8: With CASCADE=0, `half_n` is low while the write-side fill exceeds DEPTH/2. With CASCADE=1, `half_n` stays high.
- R9: `afull_n` is low while the write-side fill is at least DEPTH-PAF_GAP. `aempty_n` is low while the read-side fill is at most PAE_GAP.
- R10: Slices in a ring that share `wr_en`, `rd_en` and `din` return, across their `dout` ports, every accepted word in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| chain_head_n | input | 1 | Low marks the slice that owns both tokens after reset |
| wr_en | input | 1 | Write request |
| din | input | DW | Write data |
| wpass_in | input | 1 | Write-token pass from the previous slice |
| rd_en | input | 1 | Read request |
| rpass_in | input | 1 | Read-token pass from the previous slice |
| dout | output | DW | Registered read data |
| empty_n | output | 1 | Empty, active low, read domain |
| full_n | output | 1 | Full, active low, write domain |
| half_n | output | 1 | More than half full, active low, write domain |
| aempty_n | output | 1 | Almost empty, active low, read domain |
| afull_n | output | 1 | Almost full, active low, write domain |
| wpass_out | output | 1 | Write-token pass to the next slice |
| rpass_out | output | 1 | Read-token pass to the next slice |

## Verification
The bench uses AW=3, PAE_GAP=1 and PAF_GAP=2. With a depth of only eight words, every handful of writes crosses a wrap, a token handover and a flag threshold. Two slices in a ring give a sixteen-word buffer, so both handover directions, and the dead cycle between them, are exercised many times. A third, standalone slice receives the same stimulus, with randomly toggled pass inputs, so the single-device mode is checked against the cascaded one.

// File: rtl/sync_fifo_slice.sv
module sync_fifo_slice #(
  parameter int DW = 18,
  parameter int AW = 4,
  parameter int PAE_GAP = 2,
  parameter int PAF_GAP = 2,
  parameter bit CASCADE = 1'b0
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          chain_head_n,
  input  logic          wr_en,
  input  logic [DW-1:0] din,
  input  logic          wpass_in,
  input  logic          rd_en,
  input  logic          rpass_in,
  output logic [DW-1:0] dout,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n,
  output logic          aempty_n,
  output logic          afull_n,
  output logic          wpass_out,
  output logic          rpass_out
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_LVL = PW'(DEPTH / 2);
  localparam logic [PW-1:0] AF_LVL   = PW'(DEPTH - PAF_GAP);
  localparam logic [PW-1:0] AE_LVL   = PW'(PAE_GAP);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] wq1, wq2, rq1, rq2;
  logic [PW-1:0] wbin_nx, rbin_nx, wfill, rfill;
  logic wtok, rtok, we, re, wlast, rlast, full, empty;

  assign wbin_nx = wbin + 1'b1;
  assign rbin_nx = rbin + 1'b1;
  assign wfill = wbin - g2b(rq2);
  assign rfill = g2b(wq2) - rbin;
  assign full  = (wfill == FULL_LVL);
  assign empty = (rgray == wq2);
  assign wlast = (wbin[AW-1:0] == {AW{1'b1}});
  assign rlast = (rbin[AW-1:0] == {AW{1'b1}});
  assign we = wr_en & (wtok | !CASCADE) & !full;
  assign re = rd_en & (rtok | !CASCADE) & !empty;

  assign full_n   = !full;
  assign empty_n  = !empty;
  assign half_n   = CASCADE | (wfill <= HALF_LVL);
  assign afull_n  = (wfill < AF_LVL);
  assign aempty_n = (rfill > AE_LVL);

  always_ff @(posedge wclk)
    if (we) mem[wbin[AW-1:0]] <= din;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin <= '0;
      wgray <= '0;
      wtok <= !chain_head_n;
      wpass_out <= 1'b0;
      rq1 <= '0;
      rq2 <= '0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      wpass_out <= CASCADE && we && wlast;
      if (we) begin
        wbin <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
      if (CASCADE && we && wlast) wtok <= 1'b0;
      else if (wpass_in) wtok <= 1'b1;
    end

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rbin <= '0;
      rgray <= '0;
      rtok <= !chain_head_n;
      rpass_out <= 1'b0;
      dout <= '0;
      wq1 <= '0;
      wq2 <= '0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
      rpass_out <= CASCADE && re && rlast;
      if (re) begin
        dout <= mem[rbin[AW-1:0]];
        rbin <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
      if (CASCADE && re && rlast) rtok <= 1'b0;
      else if (rpass_in) rtok <= 1'b1;
    end
endmodule

// File: rtl/sync_fifo_slice_chk.sv
module sync_fifo_slice_chk #(
  parameter int AW = 4
) (
  input logic        wclk,
  input logic        rclk,
  input logic        rst_n,
  input logic [AW:0] wbin,
  input logic [AW:0] rbin,
  input logic        wtok,
  input logic        rtok,
  input logic        full_n,
  input logic        empty_n,
  input logic        wpass_out,
  input logic        rpass_out
);
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge wclk) disable iff (!rst_n) !full_n |=> $stable(wbin)); // R3
  AST_NO_READ_WHEN_EMPTY: assert property (@(posedge rclk) disable iff (!rst_n) !empty_n |=> $stable(rbin)); // R4
  AST_WPASS_SINGLE: assert property (@(posedge wclk) disable iff (!rst_n) wpass_out |=> !wpass_out); // R5
  AST_WPASS_AT_WRAP: assert property (@(posedge wclk) disable iff (!rst_n) $rose(wpass_out) |-> wbin[AW-1:0] == '0); // R5
  AST_WTOK_RELEASED: assert property (@(posedge wclk) disable iff (!rst_n) wpass_out |-> !wtok); // R5
  AST_RPASS_SINGLE: assert property (@(posedge rclk) disable iff (!rst_n) rpass_out |=> !rpass_out); // R6
  AST_RPASS_AT_WRAP: assert property (@(posedge rclk) disable iff (!rst_n) $rose(rpass_out) |-> rbin[AW-1:0] == '0); // R6
  AST_RTOK_RELEASED: assert property (@(posedge rclk) disable iff (!rst_n) rpass_out |-> !rtok); // R6
endmodule

bind sync_fifo_slice sync_fifo_slice_chk #(.AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wbin(wbin), .rbin(rbin),
  .wtok(wtok), .rtok(rtok), .full_n(full_n), .empty_n(empty_n),
  .wpass_out(wpass_out), .rpass_out(rpass_out)
);

// File: tb/sync_fifo_slice_tb.sv
`timescale 1ns/1ps
module sync_fifo_slice_tb;
  localparam int DW = 18, AW = 3, D = 8, PAE = 1, PAF = 2;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic solo_wpi = 1'b0, solo_rpi = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout [3];
  logic e_n [3], f_n [3], h_n [3], ae_n [3], af_n [3], wpo [3], rpo [3];

  int checks = 0, errors = 0;
  bit done = 1'b0;

  int mwp [3], mrp [3], mws1 [3], mws2 [3], mrs1 [3], mrs2 [3];
  bit mwt [3], mrt [3], mwpo [3], mrpo [3], mread [3];
  logic [DW-1:0] mdq [3];
  logic [DW-1:0] mq [3][$];
  logic [DW-1:0] sysq [$];

  always #2.5 clk = ~clk;

  sync_fifo_slice #(.DW(DW), .AW(AW), .PAE_GAP(PAE), .PAF_GAP(PAF), .CASCADE(1'b1)) u_dut (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .chain_head_n(1'b0), .wr_en(wr_en), .din(din),
    .wpass_in(wpo[1]), .rd_en(rd_en), .rpass_in(rpo[1]), .dout(dout[0]), .empty_n(e_n[0]),
    .full_n(f_n[0]), .half_n(h_n[0]), .aempty_n(ae_n[0]), .afull_n(af_n[0]),
    .wpass_out(wpo[0]), .rpass_out(rpo[0]));

  sync_fifo_slice #(.DW(DW), .AW(AW), .PAE_GAP(PAE), .PAF_GAP(PAF), .CASCADE(1'b1)) u_peer (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .chain_head_n(1'b1), .wr_en(wr_en), .din(din),
    .wpass_in(wpo[0]), .rd_en(rd_en), .rpass_in(rpo[0]), .dout(dout[1]), .empty_n(e_n[1]),
    .full_n(f_n[1]), .half_n(h_n[1]), .aempty_n(ae_n[1]), .afull_n(af_n[1]),
    .wpass_out(wpo[1]), .rpass_out(rpo[1]));

  sync_fifo_slice #(.DW(DW), .AW(AW), .PAE_GAP(PAE), .PAF_GAP(PAF), .CASCADE(1'b0)) u_solo (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .chain_head_n(1'b0), .wr_en(wr_en), .din(din),
    .wpass_in(solo_wpi), .rd_en(rd_en), .rpass_in(solo_rpi), .dout(dout[2]), .empty_n(e_n[2]),
    .full_n(f_n[2]), .half_n(h_n[2]), .aempty_n(ae_n[2]), .afull_n(af_n[2]),
    .wpass_out(wpo[2]), .rpass_out(rpo[2]));

  task automatic check(input string tag, input int s, input string nm, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s slice%0d %s act=%0h exp=%0h", tag, s, nm, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 3; s++) begin
      mwp[s] = 0; mrp[s] = 0; mws1[s] = 0; mws2[s] = 0; mrs1[s] = 0; mrs2[s] = 0;
      mwt[s] = (s != 1); mrt[s] = (s != 1);
      mwpo[s] = 0; mrpo[s] = 0; mread[s] = 0; mdq[s] = '0;
      mq[s].delete();
    end
    sysq.delete();
  endtask

  task automatic model_step();
    bit owpo [3], orpo [3];
    owpo = mwpo; orpo = mrpo;
    for (int s = 0; s < 3; s++) begin
      bit cas, win, rin, we, re;
      int owp, orp;
      cas = (s < 2);
      win = (s == 2) ? solo_wpi : owpo[1-s];
      rin = (s == 2) ? solo_rpi : orpo[1-s];
      owp = mwp[s]; orp = mrp[s];
      we = wr_en && (mwt[s] || !cas) && (owp - mrs2[s] != D);
      re = rd_en && (mrt[s] || !cas) && (orp != mws2[s]);
      mrs2[s] = mrs1[s]; mrs1[s] = orp;
      mws2[s] = mws1[s]; mws1[s] = owp;
      mwpo[s] = cas && we && (owp % D == D - 1);
      if (mwpo[s]) mwt[s] = 0; else if (win) mwt[s] = 1;
      if (we) begin
        mq[s].push_back(din);
        if (cas) sysq.push_back(din);
        mwp[s]++;
      end
      mrpo[s] = cas && re && (orp % D == D - 1);
      if (mrpo[s]) mrt[s] = 0; else if (rin) mrt[s] = 1;
      mread[s] = re;
      if (re) begin
        mdq[s] = mq[s].pop_front();
        mrp[s]++;
      end
    end
  endtask

  always @(posedge clk) if (rst_n) model_step();

  always @(negedge clk) begin
    if (!rst_n) model_reset();
    for (int s = 0; s < 3; s++) begin
      int wf, rf;
      wf = mwp[s] - mrs2[s];
      rf = mws2[s] - mrp[s];
      check(rst_n ? "R2" : "R1", s, "dout", dout[s], mdq[s]);
      check(rst_n ? "R4" : "R1", s, "empty_n", e_n[s], !(mrp[s] == mws2[s]));
      check(rst_n ? "R3" : "R1", s, "full_n", f_n[s], !(wf == D));
      check(rst_n ? "R8" : "R1", s, "half_n", h_n[s], (s < 2) ? 1 : !(wf > D / 2));
      check(rst_n ? "R9" : "R1", s, "afull_n", af_n[s], !(wf >= D - PAF));
      check(rst_n ? "R9" : "R1", s, "aempty_n", ae_n[s], !(rf <= PAE));
      check(!rst_n ? "R1" : (s == 2) ? "R7" : "R5", s, "wpass_out", wpo[s], mwpo[s]);
      check(!rst_n ? "R1" : (s == 2) ? "R7" : "R6", s, "rpass_out", rpo[s], mrpo[s]);
      if (rst_n && s < 2 && mread[s]) begin
        if (sysq.size() == 0) check("R10", s, "ring_order_underflow", 1, 0);
        else check("R10", s, "ring_order", dout[s], sysq.pop_front());
      end
    end
  end

  task automatic run_random(input int n);
    for (int i = 0; i < n; i++) begin
      int pw;
      @(negedge clk); #1;
      pw = ((i / 150) % 2 == 0) ? 75 : 30;
      wr_en = ($urandom % 100) < pw;
      rd_en = ($urandom % 100) < (100 - pw);
      din = DW'($urandom);
      solo_wpi = $urandom % 2;
      solo_rpi = $urandom % 2;
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); #1;
      wr_en = 1'b1; rd_en = 1'b0; din = DW'(i + 1);
      solo_wpi = $urandom % 2; solo_rpi = $urandom % 2;
    end
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); #1;
      wr_en = 1'b0; rd_en = 1'b1;
      solo_wpi = $urandom % 2; solo_rpi = $urandom % 2;
    end
    run_random(3000);
    @(negedge clk); #1 rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    run_random(800);
    @(negedge clk); #1 wr_en = 1'b0; rd_en = 1'b0;
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule